// File: doc/BRIEF.md
# Byte-lane parity checker and generator

This block looks after parity on a bus of four 9-bit byte lanes. The top bit of each lane carries that lane's parity. On the input side, parity trees check every lane against the selected odd or even sense. An active-low error flag goes low when any lane that takes part in the current transfer size is bad. The flag is combinational in the bus inputs and the selects.

On the read side there are two paths. Mailbox data is read straight through. When parity generation is requested for that read, the same trees that check the input bus recompute each lane's parity bit from its lower eight bits and put it in place of the stored ninth bit. While the trees are lent out this way, the error flag is held inactive. The FIFO path has its own trees between the memory read and the output register. The generate-enable and odd/even selects matter only on the edge that loads a new long word. Stored contents are never modified; only the outgoing copy changes.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane n occupies bits 9n to 9n+8 of every 36-bit bus. Bit 9n+8 is that lane's parity bit, so generation changes only bits 8, 17, 26 and 35.
- R2: With odd_i low (even sense), a lane fails when its nine bits hold an odd number of ones.
- R3: With odd_i high (odd sense), a lane fails when its nine bits hold an even number of ones.
- R4: size_i chooses the checked lanes: 2'b00 checks all four lanes, 2'b01 checks lanes 0 and 1, and 2'b10 checks lane 0 only. perr_no is low exactly when a checked lane fails.
- R5: size_i = 2'b11 selects the mailbox, and it checks all four lanes when no mailbox generation is active.
- R6: When cs_ni is low, en_i high, wr_i low, size_i 2'b11 and gen_i high, perr_no is high whatever bus_i holds.
- R7: Under the condition of R6, mbx_rd_o equals mbx_data_i with each lane's bit 8 replaced by the parity of its lower eight bits. In even sense that bit is the XOR of those bits; in odd sense it is the XNOR. The lower eight bits pass through unchanged.
- R8: When the condition of R6 does not hold, mbx_rd_o equals mbx_data_i unchanged.
- R9: On a rising clk_i edge with fifo_ld_i high, fifo_q_o loads fifo_data_i. If gen_i was high at that edge, each parity bit is regenerated as in R7, using odd_i sampled at the same edge.
- R10: On edges with fifo_ld_i low, fifo_q_o holds its value, whatever gen_i, odd_i and fifo_data_i do.
- R11: While rst_ni is low, fifo_q_o is zero.
- R12: A mailbox access that is not a generating read (cs_ni high, en_i low, a write, or gen_i low) leaves the trees checking bus_i, so perr_no follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the FIFO output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| odd_i | input | 1 | Parity sense: 1 odd, 0 even (shared by check and generate) |
| gen_i | input | 1 | Parity generation request for reads |
| cs_ni | input | 1 | Active-low port select |
| en_i | input | 1 | Port access enable |
| wr_i | input | 1 | 1 write, 0 read |
| size_i | input | 2 | 00 full, 01 two lanes, 10 one lane, 11 mailbox |
| bus_i | input | 36 | Incoming bus data to be checked |
| perr_no | output | 1 | Active-low parity error flag |
| mbx_data_i | input | 36 | Stored mailbox contents |
| mbx_rd_o | output | 36 | Mailbox read data after optional generation |
| fifo_ld_i | input | 1 | Load a new long word into the output register |
| fifo_data_i | input | 36 | Long word from the FIFO memory |
| fifo_q_o | output | 36 | FIFO output register |

## Verification
The bench builds the block with its defaults: four lanes of eight data bits plus parity. That lets random bus words hit passing and failing lanes at about equal rates in every lane, so each size mask runs in both flag states. Directed words put errors only in lanes 1 to 3 to check that the narrow sizes ignore them. Other directed words flip only the parity bit positions to show that generation rewrites exactly bits 8, 17, 26 and 35. The FIFO register is driven with gen_i and odd_i changing between loads to show they count only on a loading edge.

// File: rtl/lane_par_pkg.sv
package lane_par_pkg;
  typedef enum logic [1:0] {
    SZ_FULL = 2'b00,
    SZ_HALF = 2'b01,
    SZ_ONE  = 2'b10,
    SZ_MBX  = 2'b11
  } bus_size_e;
endpackage

// File: rtl/lane_par_bank.sv
module lane_par_bank #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int BUS_W  = LANES * LANE_W
) (
  input  logic [BUS_W-1:0] data_i,
  input  logic             odd_i,
  output logic [LANES-1:0] fail_o,
  output logic [LANES-1:0] gen_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // fail: parity of all nine bits disagrees with selected sense
    assign fail_o[l] = (^data_i[l*LANE_W +: LANE_W]) ^ odd_i;
    assign gen_o[l]  = (^data_i[l*LANE_W +: BYTE_W]) ^ odd_i;
  end
endmodule

// File: rtl/lane_mask.sv
module lane_mask
  import lane_par_pkg::*;
#(
  parameter int LANES = 4,
  localparam int HALF = (LANES > 1) ? LANES / 2 : 1
) (
  input  logic [1:0]       size_i,
  output logic [LANES-1:0] mask_o
);
  always_comb begin
    mask_o = '0;
    unique case (bus_size_e'(size_i))
      SZ_HALF: mask_o[HALF-1:0] = '1;
      SZ_ONE:  mask_o[0]        = 1'b1;
      default: mask_o           = '1;
    endcase
  end
endmodule

// File: rtl/lane_subst.sv
module lane_subst #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int BUS_W  = LANES * LANE_W
) (
  input  logic [BUS_W-1:0] data_i,
  input  logic [LANES-1:0] par_i,
  input  logic             en_i,
  output logic [BUS_W-1:0] data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_o[l*LANE_W +: BYTE_W] = data_i[l*LANE_W +: BYTE_W];
    assign data_o[l*LANE_W + BYTE_W]  = en_i ? par_i[l] : data_i[l*LANE_W + BYTE_W];
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lane_par_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int BUS_W  = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             odd_i,
  input  logic             gen_i,
  input  logic             cs_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [1:0]       size_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             perr_no,
  input  logic [BUS_W-1:0] mbx_data_i,
  output logic [BUS_W-1:0] mbx_rd_o,
  input  logic             fifo_ld_i,
  input  logic [BUS_W-1:0] fifo_data_i,
  output logic [BUS_W-1:0] fifo_q_o
);
  logic             mbx_gen;
  logic [BUS_W-1:0] tree_in;
  logic [LANES-1:0] tree_fail, tree_gen, chk_mask;
  logic [LANES-1:0] ff_fail_unused, ff_gen;
  logic [BUS_W-1:0] ff_next;
  logic [BUS_W-1:0] fifo_q;

  // shared trees are lent to mailbox generation on a generating read
  assign mbx_gen = ~cs_ni & en_i & ~wr_i & (bus_size_e'(size_i) == SZ_MBX) & gen_i;
  assign tree_in = mbx_gen ? mbx_data_i : bus_i;

  lane_par_bank #(.LANES(LANES), .BYTE_W(BYTE_W)) u_shared_bank (
    .data_i (tree_in),
    .odd_i  (odd_i),
    .fail_o (tree_fail),
    .gen_o  (tree_gen)
  );

  lane_mask #(.LANES(LANES)) u_mask (
    .size_i (size_i),
    .mask_o (chk_mask)
  );

  assign perr_no = mbx_gen | ~|(tree_fail & chk_mask);

  lane_subst #(.LANES(LANES), .BYTE_W(BYTE_W)) u_mbx_subst (
    .data_i (mbx_data_i),
    .par_i  (tree_gen),
    .en_i   (mbx_gen),
    .data_o (mbx_rd_o)
  );

  // FIFO read path: own trees ahead of the output register
  lane_par_bank #(.LANES(LANES), .BYTE_W(BYTE_W)) u_fifo_bank (
    .data_i (fifo_data_i),
    .odd_i  (odd_i),
    .fail_o (ff_fail_unused),
    .gen_o  (ff_gen)
  );

  lane_subst #(.LANES(LANES), .BYTE_W(BYTE_W)) u_fifo_subst (
    .data_i (fifo_data_i),
    .par_i  (ff_gen),
    .en_i   (gen_i),
    .data_o (ff_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fifo_q <= '0;
    else if (fifo_ld_i) fifo_q <= ff_next;
  end

  assign fifo_q_o = fifo_q;
endmodule

// File: rtl/lane_parity_chk.sv
module lane_parity_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int BUS_W  = LANES * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             odd_i,
  input logic             gen_i,
  input logic             cs_ni,
  input logic             en_i,
  input logic             wr_i,
  input logic [1:0]       size_i,
  input logic [BUS_W-1:0] bus_i,
  input logic             perr_no,
  input logic [BUS_W-1:0] mbx_data_i,
  input logic [BUS_W-1:0] mbx_rd_o,
  input logic             fifo_ld_i,
  input logic [BUS_W-1:0] fifo_data_i,
  input logic [BUS_W-1:0] fifo_q_o
);
  logic gen_rd;
  logic [BUS_W-1:0] low_mask;
  assign gen_rd = !cs_ni && en_i && !wr_i && size_i == 2'b11 && gen_i;
  always_comb begin
    low_mask = '1;
    for (int l = 0; l < LANES; l++) low_mask[l*LANE_W + BYTE_W] = 1'b0;
  end

  // R6
  flag_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_rd |-> perr_no);

  // R7
  low_bits_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_rd |-> ((mbx_rd_o & low_mask) == (mbx_data_i & low_mask)));

  // R8
  mbx_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_rd |-> (mbx_rd_o == mbx_data_i));

  // R4
  one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b10) |-> (perr_no == !((^bus_i[LANE_W-1:0]) ^ odd_i)));

  // R9
  raw_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_ld_i && !gen_i) |=> (fifo_q_o == $past(fifo_data_i)));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_ld_i |=> $stable(fifo_q_o));

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) reset_zero_chk: assert (fifo_q_o == '0);
  end
endmodule

bind lane_parity_unit lane_parity_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_lane_parity_unit.sv
`timescale 1ns/1ps
module tb_lane_parity_unit;
  localparam int LANES = 4;
  localparam int BW    = 8;
  localparam int LW    = BW + 1;
  localparam int W     = LANES * LW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic odd_i = 0, gen_i = 0, cs_ni = 1, en_i = 0, wr_i = 0, fifo_ld_i = 0;
  logic [1:0] size_i = 2'b00;
  logic [W-1:0] bus_i = '0, mbx_data_i = '0, fifo_data_i = '0;
  logic perr_no;
  logic [W-1:0] mbx_rd_o, fifo_q_o;
  logic [W-1:0] exp_fifo;
  int checks = 0, fails = 0;

  always #2 clk_i = ~clk_i;

  lane_parity_unit #(.LANES(LANES), .BYTE_W(BW)) dut (.*);

  function automatic int ones(input logic [W-1:0] d, input int lo, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += d[lo+i];
    return c;
  endfunction

  function automatic logic [W-1:0] regen(input logic [W-1:0] d, input logic odd);
    logic [W-1:0] r = d;
    for (int l = 0; l < LANES; l++) r[l*LW+BW] = ((ones(d, l*LW, BW) % 2) == 1) ^ odd;
    return r;
  endfunction

  function automatic logic exp_flag();
    int nchk;
    logic bad = 0;
    if (!cs_ni && en_i && !wr_i && size_i == 2'b11 && gen_i) return 1'b1;
    nchk = (size_i == 2'b01) ? LANES/2 : (size_i == 2'b10) ? 1 : LANES;
    for (int l = 0; l < nchk; l++)
      if (((ones(bus_i, l*LW, LW) % 2) == 1) != odd_i) bad = 1;
    return !bad;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        exp_fifo <= '0;
    else if (fifo_ld_i) exp_fifo <= gen_i ? regen(fifo_data_i, odd_i) : fifo_data_i;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic g;
    string t;
    g = !cs_ni && en_i && !wr_i && size_i == 2'b11 && gen_i;
    if (g) t = "R6";
    else if (size_i == 2'b11) t = (cs_ni || !en_i || wr_i || !gen_i) ? "R12" : "R5";
    else if (size_i != 2'b00) t = "R4";
    else t = odd_i ? "R3" : "R2";
    chk(t, W'(perr_no), W'(exp_flag()));
    chk(g ? "R7" : "R8", mbx_rd_o, g ? regen(mbx_data_i, odd_i) : mbx_data_i);
  endtask

  // one cycle: check register, drive, check combinational outputs
  task automatic step(input logic o, input logic g, input logic cs, input logic e,
                      input logic w, input logic [1:0] s, input logic [W-1:0] b,
                      input logic [W-1:0] m, input logic ld, input logic [W-1:0] f);
    @(negedge clk_i);
    chk(!rst_ni ? "R11" : "R9 R10", fifo_q_o, exp_fifo);
    odd_i = o; gen_i = g; cs_ni = cs; en_i = e; wr_i = w; size_i = s;
    bus_i = b; mbx_data_i = m; fifo_ld_i = ld; fifo_data_i = f;
    #1 check_all();
  endtask

  function automatic logic [W-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] hold;
    step(0, 1, 0, 1, 0, 2'b11, '0, rnd(), 1, rnd());
    chk("R11", fifo_q_o, '0);
    step(0, 0, 1, 0, 0, 2'b00, '0, '0, 0, '0);
    rst_ni = 1'b1;
    // R1: parity bit positions, odd sense on zero data
    step(1, 1, 0, 1, 0, 2'b11, '1, '0, 0, '0);
    chk("R1", mbx_rd_o, 36'h804020100);
    chk("R6", W'(perr_no), W'(1));
    // R12: same access with port deselected checks the bad bus
    step(1, 1, 1, 1, 0, 2'b11, 36'h000000001, '0, 0, '0);
    chk("R12", W'(perr_no), W'(0));
    // R4: errors only in lanes 1..3 are ignored in single-lane mode
    step(0, 0, 1, 0, 0, 2'b10, 36'h001_0040_200 & ~36'h1ff, '0, 0, '0);
    chk("R4", W'(perr_no), W'(1));
    step(0, 0, 1, 0, 0, 2'b01, 36'h000000200, '0, 0, '0);
    chk("R4", W'(perr_no), W'(0));
    step(0, 0, 1, 0, 0, 2'b01, 36'h004000000, '0, 0, '0);
    chk("R4", W'(perr_no), W'(1));
    step(0, 0, 1, 0, 0, 2'b00, 36'h800000000, '0, 0, '0);
    chk("R2", W'(perr_no), W'(0));
    step(1, 0, 1, 0, 0, 2'b00, 36'h804020100, '0, 0, '0);
    chk("R3", W'(perr_no), W'(1));
    // R9: generated load, then R10 hold while selects toggle
    step(0, 1, 1, 0, 0, 2'b00, '0, '0, 1, 36'h1ff0ff001);
    hold = regen(36'h1ff0ff001, 0);
    for (int i = 0; i < 4; i++)
      step(i[0], ~i[0], 1, 0, 0, 2'b00, '0, '0, 0, rnd());
    chk("R10", fifo_q_o, hold);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3) == 0,
           $urandom_range(0,3) != 0, $urandom_range(0,3) == 0, 2'($urandom_range(0,3)),
           rnd(), rnd(), $urandom_range(0,1), rnd());
    step(0, 0, 1, 0, 0, 2'b00, '0, '0, 0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule